// File: doc/BRIEF.md
# Inter-thread cell window controller

This block places a window for an array of inter-thread communication cells in a 64-bit address space and decodes accesses inside it. A packed segment-attribute word, written through its own port, sets the window's enable, its size as a power of two and its base address. An access that lands inside an enabled window is split into a view code and a cell index. The spacing between cells is set by a programmable grain field.

Cell views produce a one-cycle cell-select strobe for the cell storage, which lies outside this block. A special view reaches a control and status word. That word holds three sticky error flags, the grain field and a read-only cell count. Byte and half-word accesses are refused with a bus-error response and leave a sticky flag behind. Every access that hits the window gets exactly one response, one clock after the request. An access that misses the window gets no response, so another target may answer it.

Top module: `itc_window_ctrl`

## Requirements
- R1: After reset the attribute word reads 0x22, which means the window is disabled with a size field of 17. The control word reads NUM_CELLS<<16, with the grain field and all flags at zero.
- R2: In the attribute word, bit 0 enables the window and bits 5:1 hold log2 of its size. The base is (attr & 0xFFFFFFFFE000) << 4. A request hits only while the window is enabled and base <= addr < base + size. A miss gets no response and no strobe.
- R3: The offset is addr - base. Its bits 6:3 give the view code. The cell index is offset >> (7 + grain), where grain is bits 10:8 of the control word.
- R4: A 4-byte or 8-byte hit on views 0 to 5 pulses cell_sel_o for one cycle. The pulse carries the index, view, write flag and write data, and the response has no error.
- R5: View 15 reaches the control word. A read returns it. A write clears each flag at bits 2:0 whose data bit is 1, and loads bits 10:8 from the data.
- R6: A hit of 1 or 2 bytes (size_i of 0 or 1) sets flag bit 2 and gets an error response. It gives no strobe and leaves the control word's grain unchanged.
- R7: A hit on views 6 to 14 gets an error response. It gives no strobe and changes no flag.
- R8: A pulse on exec_err_i sets flag bit 0, and a pulse on parity_err_i sets flag bit 1. Each flag stays set until a write clears it.
- R9: Bits 16 and up of the control word keep the cell count. A write does not change them.
- R10: The response, and any strobe, appear in the cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attr_we_i | input | 1 | Write strobe for the attribute word |
| attr_wdata_i | input | 64 | New attribute word |
| attr_o | output | 64 | Current attribute word |
| req_i | input | 1 | Bus request valid |
| we_i | input | 1 | Request is a write |
| addr_i | input | AW | Byte address |
| size_i | input | 2 | log2 of the access bytes (0=1, 1=2, 2=4, 3=8) |
| wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response for a hit |
| rsp_err_o | output | 1 | Response is a bus error |
| rdata_o | output | 64 | Read data (the control word for view 15, zero otherwise) |
| exec_err_i | input | 1 | Sets the execution-error flag |
| parity_err_i | input | 1 | Sets the parity-error flag |
| ctrl_o | output | 64 | Current control word |
| cell_sel_o | output | 1 | Cell access strobe |
| cell_idx_o | output | IDX_W | Cell index of the strobe |
| cell_view_o | output | 4 | View code of the strobe |
| cell_we_o | output | 1 | Strobe is a write |
| cell_wdata_o | output | 64 | Write data of the strobe |

## Verification
The bench builds the block with NUM_CELLS set to 12 rather than the default of 16. This shows that the count field follows the parameter and is not a fixed value. AW stays at 64, and IDX_W at 8 is wide enough that the index at grain 2 shows its full value. A 4 KiB window at a nonzero base lets both window edges be reached by addresses next to them. The bench then grows the window, disables it and moves its base. It also changes the grain between 0 and 2, which moves the index to different address bits.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam logic [3:0] VIEW_CTRL     = 4'd15;
  localparam logic [3:0] VIEW_CELL_MAX = 4'd5;
  localparam int unsigned STRIDE_MIN   = 7;
  localparam int unsigned FLAG_EXEC    = 0;
  localparam int unsigned FLAG_PARITY  = 1;
  localparam int unsigned FLAG_BUS     = 2;
  localparam int unsigned GRAIN_LSB    = 8;
  localparam int unsigned CNT_LSB      = 16;
  localparam logic [63:0] ATTR_RESET   = 64'h22;
  localparam logic [63:0] BASE_MASK    = 64'h0000_FFFF_FFFF_E000;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;
endpackage

// File: rtl/itc_seg_attr.sv
module itc_seg_attr
  import itc_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [63:0]   wdata_i,
  output logic [63:0]   attr_o,
  output logic          en_o,
  output logic [4:0]    size_log_o,
  output logic [AW-1:0] base_o
);
  logic [63:0] attr_q;
  logic [63:0] base_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   attr_q <= ATTR_RESET;
    else if (we_i) attr_q <= wdata_i;
  end

  assign base_full  = (attr_q & BASE_MASK) << 4;
  assign attr_o     = attr_q;
  assign en_o       = attr_q[0];
  assign size_log_o = attr_q[5:1];
  assign base_o     = base_full[AW-1:0];

  // Low 17 bits of the base are always zero.
  assert_base_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o[16:0] == '0);
endmodule

// File: rtl/itc_addr_decode.sv
module itc_addr_decode
  import itc_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned IDX_W = 8
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             en_i,
  input  logic [4:0]       size_log_i,
  input  logic [AW-1:0]    base_i,
  input  logic [2:0]       grain_i,
  output logic             hit_o,
  output logic [3:0]       view_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [AW-1:0] offset;
  logic [AW-1:0] above;
  logic [AW-1:0] cell_pos;
  logic [3:0]    shift;

  assign offset   = addr_i - base_i;
  assign above    = offset >> size_log_i;
  assign shift    = 4'(STRIDE_MIN) + {1'b0, grain_i};
  assign cell_pos = offset >> shift;

  assign hit_o  = en_i && (addr_i >= base_i) && (above == '0);
  assign view_o = offset[6:3];
  assign idx_o  = cell_pos[IDX_W-1:0];
endmodule

// File: rtl/itc_ctrl_csr.sv
module itc_ctrl_csr
  import itc_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 16,
  parameter int unsigned CNT_W     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [63:0] wdata_i,
  input  logic        set_bus_i,
  input  logic        set_exec_i,
  input  logic        set_parity_i,
  output logic [63:0] ctrl_o,
  output logic [2:0]  grain_o
);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(NUM_CELLS);

  logic [2:0]       flags_q;
  logic [2:0]       flags_d;
  logic [2:0]       set_vec;
  logic [2:0]       grain_q;
  logic [CNT_W-1:0] cnt_q;

  assign set_vec = {set_bus_i, set_parity_i, set_exec_i};

  always_comb begin
    flags_d = flags_q;
    if (wr_i) flags_d = flags_d & ~wdata_i[2:0];
    flags_d = flags_d | set_vec;  // a new error wins over a clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      grain_q <= '0;
      cnt_q   <= CNT_RST;
    end else begin
      flags_q <= flags_d;
      if (wr_i) grain_q <= wdata_i[GRAIN_LSB +: 3];
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[2:0]               = flags_q;
    ctrl_o[GRAIN_LSB +: 3]    = grain_q;
    ctrl_o[CNT_LSB +: CNT_W]  = cnt_q;
  end
  assign grain_o = grain_q;

  assert_cnt_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ctrl_o[CNT_LSB +: CNT_W]));
  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_o[FLAG_EXEC]) && !$past(wr_i)) |-> ctrl_o[FLAG_EXEC]);
endmodule

// File: rtl/itc_window_ctrl.sv
module itc_window_ctrl
  import itc_pkg::*;
#(
  parameter int unsigned AW        = 64,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned NUM_CELLS = 16,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             attr_we_i,
  input  logic [63:0]      attr_wdata_i,
  output logic [63:0]      attr_o,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [1:0]       size_i,
  input  logic [63:0]      wdata_i,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [63:0]      rdata_o,
  input  logic             exec_err_i,
  input  logic             parity_err_i,
  output logic [63:0]      ctrl_o,
  output logic             cell_sel_o,
  output logic [IDX_W-1:0] cell_idx_o,
  output logic [3:0]       cell_view_o,
  output logic             cell_we_o,
  output logic [63:0]      cell_wdata_o
);
  logic             en;
  logic [4:0]       size_log;
  logic [AW-1:0]    base;
  logic [2:0]       grain;
  logic             hit;
  logic [3:0]       view;
  logic [IDX_W-1:0] idx;
  logic             acc, narrow, is_ctrl, is_cell, bad_view;
  logic             ctrl_wr;

  itc_seg_attr #(.AW(AW)) u_attr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (attr_we_i),
    .wdata_i    (attr_wdata_i),
    .attr_o     (attr_o),
    .en_o       (en),
    .size_log_o (size_log),
    .base_o     (base)
  );

  itc_addr_decode #(.AW(AW), .IDX_W(IDX_W)) u_dec (
    .addr_i     (addr_i),
    .en_i       (en),
    .size_log_i (size_log),
    .base_i     (base),
    .grain_i    (grain),
    .hit_o      (hit),
    .view_o     (view),
    .idx_o      (idx)
  );

  assign acc      = req_i && hit;
  assign narrow   = (size_i == SZ_B) || (size_i == SZ_H);
  assign is_ctrl  = acc && !narrow && (view == VIEW_CTRL);
  assign is_cell  = acc && !narrow && (view <= VIEW_CELL_MAX);
  assign bad_view = acc && !narrow && !is_ctrl && !is_cell;
  assign ctrl_wr  = is_ctrl && we_i;

  itc_ctrl_csr #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (ctrl_wr),
    .wdata_i      (wdata_i),
    .set_bus_i    (acc && narrow),
    .set_exec_i   (exec_err_i),
    .set_parity_i (parity_err_i),
    .ctrl_o       (ctrl_o),
    .grain_o      (grain)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_err_o    <= 1'b0;
      rdata_o      <= '0;
      cell_sel_o   <= 1'b0;
      cell_idx_o   <= '0;
      cell_view_o  <= '0;
      cell_we_o    <= 1'b0;
      cell_wdata_o <= '0;
    end else begin
      rsp_valid_o <= acc;
      rsp_err_o   <= (acc && narrow) || bad_view;
      rdata_o     <= (is_ctrl && !we_i) ? ctrl_o : '0;
      cell_sel_o  <= is_cell;
      if (is_cell) begin
        cell_idx_o   <= idx;
        cell_view_o  <= view;
        cell_we_o    <= we_i;
        cell_wdata_o <= wdata_i;
      end
    end
  end

  assert_strobe_has_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_sel_o |-> (rsp_valid_o && !rsp_err_o && cell_view_o <= VIEW_CELL_MAX));
  assert_narrow_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit && size_i < 2'd2) |=> (rsp_err_o && !cell_sel_o && ctrl_o[FLAG_BUS]));
  assert_miss_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || !en) |=> (!rsp_valid_o && !cell_sel_o));
  assert_rsp_timing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_i));
  assert_badview_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_view && !exec_err_i && !parity_err_i) |=> $stable(ctrl_o[2:0]));
endmodule

// File: tb/sim_itc_window_ctrl.sv
`timescale 1ns/1ps
module sim_itc_window_ctrl;
  localparam int unsigned AW = 64, IDX_W = 8, NUM_CELLS = 12, CNT_W = 8;

  typedef struct {
    int          stamp;
    string       req;
    logic        valid;
    logic        err;
    logic [63:0] rdata;
    logic        sel;
    logic [7:0]  idx;
    logic [3:0]  view;
    logic        we;
    logic [63:0] wdata;
  } exp_t;

  logic clk = 0, rst_ni = 0;
  logic attr_we = 0, req = 0, we = 0, exec_err = 0, parity_err = 0;
  logic [63:0] attr_wdata = 0, wdata = 0, attr_o, rdata_o, ctrl_o, cell_wdata_o;
  logic [AW-1:0] addr = 0;
  logic [1:0] size = 0;
  logic rsp_valid_o, rsp_err_o, cell_sel_o, cell_we_o;
  logic [IDX_W-1:0] cell_idx_o;
  logic [3:0] cell_view_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  itc_window_ctrl #(.AW(AW), .IDX_W(IDX_W), .NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .attr_we_i(attr_we), .attr_wdata_i(attr_wdata),
    .attr_o(attr_o), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
    .rdata_o(rdata_o), .exec_err_i(exec_err), .parity_err_i(parity_err),
    .ctrl_o(ctrl_o), .cell_sel_o(cell_sel_o), .cell_idx_o(cell_idx_o),
    .cell_view_o(cell_view_o), .cell_we_o(cell_we_o), .cell_wdata_o(cell_wdata_o));

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: compare the response one cycle after each request
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " rsp_valid"}, 64'(rsp_valid_o), 64'(e.valid));
      chk({e.req, " cell_sel"}, 64'(cell_sel_o), 64'(e.sel));
      if (e.valid) begin
        chk({e.req, " rsp_err"}, 64'(rsp_err_o), 64'(e.err));
        chk({e.req, " rdata"}, rdata_o, e.rdata);
      end
      if (e.sel) begin
        chk({e.req, " idx"}, 64'(cell_idx_o), 64'(e.idx));
        chk({e.req, " view"}, 64'(cell_view_o), 64'(e.view));
        chk({e.req, " we"}, 64'(cell_we_o), 64'(e.we));
        chk({e.req, " wdata"}, cell_wdata_o, e.wdata);
      end
    end else if (rst_ni && (rsp_valid_o || cell_sel_o)) begin
      chk("R10 unexpected response", 64'(rsp_valid_o | cell_sel_o), 64'd0);
    end
  end

  task automatic acc(string r, logic w, logic [63:0] a, logic [1:0] s, logic [63:0] d,
                     logic ev, logic ee, logic [63:0] er,
                     logic es, logic [7:0] ei, logic [3:0] evw);
    exp_t e;
    @(negedge clk);
    e.stamp = cyc; e.req = r; e.valid = ev; e.err = ee; e.rdata = er;
    e.sel = es; e.idx = ei; e.view = evw; e.we = w; e.wdata = d;
    q.push_back(e);
    req = 1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    @(negedge clk);
  endtask

  task automatic set_attr(logic [63:0] v);
    @(negedge clk);
    attr_we = 1; attr_wdata = v;
    @(negedge clk);
    attr_we = 0;
  endtask

  localparam logic [63:0] CNT = 64'(NUM_CELLS) << 16;

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 attr reset", attr_o, 64'h22);
    chk("R1 ctrl reset", ctrl_o, CNT);
    acc("R1 disabled window", 0, 64'h78, 2'd3, 0, 0, 0, 0, 0, 0, 0);

    set_attr(64'h2019);  // base 0x20000, 4 KiB, enabled
    acc("R5 ctrl read", 0, 64'h20078, 2'd3, 0, 1, 0, CNT, 0, 0, 0);
    acc("R3 R4 cell write", 1, 64'h20190, 2'd3, 64'hABCD, 1, 0, 0, 1, 8'd3, 4'd2);
    acc("R4 word read", 0, 64'h20010, 2'd2, 0, 1, 0, 0, 1, 8'd0, 4'd2);
    acc("R5 R9 ctrl write", 1, 64'h20078, 2'd3, 64'h0000_0000_00FF_0200, 1, 0, 0, 0, 0, 0);
    chk("R5 R9 ctrl after grain", ctrl_o, CNT | 64'h200);
    acc("R3 grain 2 index", 0, 64'h20628, 2'd3, 0, 1, 0, 0, 1, 8'd3, 4'd5);
    acc("R6 byte access", 1, 64'h20000, 2'd0, 64'h1, 1, 1, 0, 0, 0, 0);
    chk("R6 bus flag", ctrl_o, CNT | 64'h204);
    acc("R6 half ctrl write", 1, 64'h20078, 2'd1, 64'h0, 1, 1, 0, 0, 0, 0);
    chk("R6 ctrl untouched", ctrl_o, CNT | 64'h204);
    acc("R7 view 7", 0, 64'h20038, 2'd3, 0, 1, 1, 0, 0, 0, 0);
    chk("R7 flags unchanged", ctrl_o, CNT | 64'h204);
    acc("R2 above top", 0, 64'h21000, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    acc("R2 below base", 0, 64'h1FFF8, 2'd3, 0, 0, 0, 0, 0, 0, 0);

    @(negedge clk);
    exec_err = 1; parity_err = 1;
    @(negedge clk);
    exec_err = 0; parity_err = 0;
    repeat (2) @(negedge clk);
    chk("R8 sticky flags", ctrl_o, CNT | 64'h207);
    acc("R5 clear exec", 1, 64'h20078, 2'd3, 64'h201, 1, 0, 0, 0, 0, 0);
    chk("R5 partial clear", ctrl_o, CNT | 64'h206);

    set_attr(64'h201B);  // 8 KiB
    acc("R2 grown window", 0, 64'h21000, 2'd3, 0, 1, 0, 0, 1, 8'd8, 4'd0);
    set_attr(64'h201A);  // disabled
    acc("R2 disabled", 0, 64'h20078, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    set_attr(64'h4019);  // base 0x40000
    acc("R2 moved base", 0, 64'h40078, 2'd3, 0, 1, 0, CNT | 64'h206, 0, 0, 0);
    acc("R2 old base miss", 0, 64'h20078, 2'd3, 0, 0, 0, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    chk("R10 queue drained", 64'(q.size()), 64'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule